// File: doc/BRIEF.md
# Byte-Laned SRAM Emulator

This block stands in for an asynchronous 16-bit static RAM inside a clocked design. The active-low select, write strobe, output enable and the two per-byte enables are sampled on a fast system clock, and the block decodes each sample into one of four modes: standby, read, write or outputs quiet. Read data comes out on a plain 16-bit output. A two-bit drive flag, one bit per byte lane, takes the place of the tri-state pins. A lane whose flag is low counts as high impedance.

A write spans the whole stretch in which both select and write strobe are low. It lands in the array on the first sample where that stretch has ended, with the address, data and byte enables taken from the last sample inside it. This matches a part that latches data on the trailing edge of the write pulse. A standby flag reports when the device is deselected.

Top module: `sram16_lane_emu`

## Requirements
- R1: `rst` is synchronous and active high. After any clock edge with `rst` high, `rdrive` is 2'b00, `standby` is 1 and `rdata` is 0. Reset does not alter stored array contents.
- R2: A sample with `sel_n`=0, `wr_n`=1 and `oe_n`=0 is a read. The stored word at `addr` shows on `rdata`, with the enabled lanes' `rdrive` bits at 1, after the second rising edge that follows the inputs being applied.
- R3: `lane_en_n[0]` gates bits 7:0 and `rdrive[0]`. `lane_en_n[1]` gates bits 15:8 and `rdrive[1]`. A lane whose `rdrive` bit is 0 shows zero on `rdata`.
- R4: A sample with `sel_n`=0 and `wr_n`=0 is a write, whatever the value of `oe_n`. Only lanes whose `lane_en_n` bit is 0 are stored. With both bits at 1, nothing is stored.
- R5: For a sample that is a write, both `rdrive` bits are 0.
- R6: A sample with `sel_n`=1 gives `standby`=1 and `rdrive`=2'b00, and stores nothing, whatever the other inputs are.
- R7: A sample with `sel_n`=0 and `wr_n`=1, and with either `oe_n`=1 or `lane_en_n`=2'b11, gives `rdrive`=2'b00 and `standby`=0.
- R8: A write commits on the first sample where `sel_n` or `wr_n` is back at 1. It uses the address, data and lane enables of the last sample in which both were 0. Earlier samples of the same write store nothing, and this holds whether `wr_n` or `sel_n` ends the write.
- R9: A read sampled on the same cycle as a write commit, at the same address, returns the newly written lanes. Lanes not written, and other addresses, return array contents.
- R10: The array holds 2^ARRAY_AW words, indexed by the low ARRAY_AW address bits. The default of 11 gives 2048 words. A setting of 17 gives the full 128K-word space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Device select, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lane_en_n | input | 2 | Byte enables, active low; bit 0 low byte, bit 1 high byte |
| addr | input | 17 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on undriven lanes |
| rdrive | output | 2 | Per-lane drive flag, standing in for the tri-state pins |
| standby | output | 1 | High when the device is deselected |

## Verification
A write commit and a read of the same word can land on one clock edge. This happens when the pins go straight from a write to a read with no idle sample between them. The bench provokes it by following a write directly with a read of the same address, once with both lanes written and once with only the low lane. It expects the new bytes in the written lanes and the older array bytes in the rest. A back-to-back read at a different address confirms that the bypass does not fire falsely.

// File: rtl/sram16_emu_pkg.sv
`timescale 1ns/1ps
package sram16_emu_pkg;
  typedef enum logic [1:0] {
    EMU_STANDBY = 2'd0,
    EMU_READ    = 2'd1,
    EMU_WRITE   = 2'd2,
    EMU_QUIET   = 2'd3
  } emu_mode_e;
endpackage

// File: rtl/sram16_emu_sampler.sv
`timescale 1ns/1ps
// Registers every pin once on the system clock; reset leaves the device idle.
module sram16_emu_sampler #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              s_sel_n,
  output logic              s_wr_n,
  output logic              s_oe_n,
  output logic [LANES-1:0]  s_lane_n,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s_sel_n  <= 1'b1;
      s_wr_n   <= 1'b1;
      s_oe_n   <= 1'b1;
      s_lane_n <= '1;
      s_addr   <= '0;
      s_data   <= '0;
    end else begin
      s_sel_n  <= sel_n;
      s_wr_n   <= wr_n;
      s_oe_n   <= oe_n;
      s_lane_n <= lane_en_n;
      s_addr   <= addr;
      s_data   <= wdata;
    end
  end
endmodule

// File: rtl/sram16_emu_decode.sv
`timescale 1ns/1ps
// Turns one sampled control set into a mode and per-lane read requests.
module sram16_emu_decode
  import sram16_emu_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             s_sel_n,
  input  logic             s_wr_n,
  input  logic             s_oe_n,
  input  logic [LANES-1:0] s_lane_n,
  output emu_mode_e        mode,
  output logic [LANES-1:0] lane_rd
);
  always_comb begin
    if (s_sel_n)                              mode = EMU_STANDBY;
    else if (!s_wr_n)                         mode = EMU_WRITE;
    else if (!s_oe_n && (s_lane_n != '1))     mode = EMU_READ;
    else                                      mode = EMU_QUIET;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign lane_rd[g] = (mode == EMU_READ) && !s_lane_n[g];
  end
endmodule

// File: rtl/sram16_emu_wr_track.sv
`timescale 1ns/1ps
// Holds the previous sample and flags the sample on which a write window closes.
module sram16_emu_wr_track
  import sram16_emu_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  emu_mode_e         mode,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_data,
  input  logic [LANES-1:0]  s_lane_n,
  output logic [ADDR_W-1:0] p_addr,
  output logic [DATA_W-1:0] p_data,
  output logic [LANES-1:0]  lane_wr
);
  logic             p_in_write;
  logic [LANES-1:0] p_lane_n;
  logic             closing;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_in_write <= 1'b0;
      p_lane_n   <= '1;
      p_addr     <= '0;
      p_data     <= '0;
    end else begin
      p_in_write <= (mode == EMU_WRITE);
      p_lane_n   <= s_lane_n;
      p_addr     <= s_addr;
      p_data     <= s_data;
    end
  end

  assign closing = p_in_write && (mode != EMU_WRITE);

  for (genvar g = 0; g < LANES; g++) begin : g_wr
    assign lane_wr[g] = closing && !p_lane_n[g];
  end
endmodule

// File: rtl/sram16_emu_lane.sv
`timescale 1ns/1ps
// One byte lane: inferable RAM with a registered read and a one-cycle commit bypass.
module sram16_emu_lane #(
  parameter int LANE_W = 8,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [LANE_W-1:0] wr_data,
  input  logic              bypass,
  output logic [LANE_W-1:0] q,
  output logic              drive
);
  localparam int DEPTH = 1 << AW;

  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] mem_q;
  logic [LANE_W-1:0] byp_q;
  logic              byp_sel;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    mem_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive   <= 1'b0;
      byp_sel <= 1'b0;
      byp_q   <= '0;
    end else begin
      drive   <= rd_en;
      byp_sel <= bypass;
      byp_q   <= wr_data;
    end
  end

  assign q = !drive ? '0 : (byp_sel ? byp_q : mem_q);
endmodule

// File: rtl/sram16_lane_emu.sv
`timescale 1ns/1ps
module sram16_lane_emu
  import sram16_emu_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int LANE_W   = 8,
  parameter int ARRAY_AW = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sel_n,
  input  logic                       wr_n,
  input  logic                       oe_n,
  input  logic [DATA_W/LANE_W-1:0]   lane_en_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [DATA_W/LANE_W-1:0]   rdrive,
  output logic                       standby
);
  localparam int LANES = DATA_W / LANE_W;

  logic              s_sel_n, s_wr_n, s_oe_n;
  logic [LANES-1:0]  s_lane_n;
  logic [ADDR_W-1:0] s_addr, p_addr;
  logic [DATA_W-1:0] s_data, p_data;
  logic [LANES-1:0]  lane_rd, lane_wr;
  logic              same_word;
  emu_mode_e         mode;

  sram16_emu_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_sampler (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
    .lane_en_n(lane_en_n), .addr(addr), .wdata(wdata),
    .s_sel_n(s_sel_n), .s_wr_n(s_wr_n), .s_oe_n(s_oe_n),
    .s_lane_n(s_lane_n), .s_addr(s_addr), .s_data(s_data)
  );

  sram16_emu_decode #(.LANES(LANES)) u_decode (
    .s_sel_n(s_sel_n), .s_wr_n(s_wr_n), .s_oe_n(s_oe_n),
    .s_lane_n(s_lane_n), .mode(mode), .lane_rd(lane_rd)
  );

  sram16_emu_wr_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_track (
    .clk(clk), .rst(rst), .mode(mode), .s_addr(s_addr), .s_data(s_data),
    .s_lane_n(s_lane_n), .p_addr(p_addr), .p_data(p_data), .lane_wr(lane_wr)
  );

  assign same_word = (p_addr == s_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram16_emu_lane #(.LANE_W(LANE_W), .AW(ARRAY_AW)) u_lane (
      .clk(clk), .rst(rst),
      .rd_en(lane_rd[g]),
      .rd_addr(s_addr[ARRAY_AW-1:0]),
      .wr_en(lane_wr[g]),
      .wr_addr(p_addr[ARRAY_AW-1:0]),
      .wr_data(p_data[g*LANE_W +: LANE_W]),
      .bypass(lane_wr[g] && same_word),
      .q(rdata[g*LANE_W +: LANE_W]),
      .drive(rdrive[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) standby <= 1'b1;
    else     standby <= (mode == EMU_STANDBY);
  end
endmodule

// File: rtl/sram16_lane_emu_chk.sv
`timescale 1ns/1ps
module sram16_lane_emu_chk #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sel_n,
  input logic                     wr_n,
  input logic                     oe_n,
  input logic [DATA_W/LANE_W-1:0] lane_en_n,
  input logic [DATA_W-1:0]        rdata,
  input logic [DATA_W/LANE_W-1:0] rdrive,
  input logic                     standby
);
  localparam int LANES = DATA_W / LANE_W;

  logic [1:0] age;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)            age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm = (age >= 2'd2);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (rdrive == '0 && standby && rdata == '0)); // R1

  AST_STANDBY_TRACK: assert property (@(posedge clk) disable iff (rst || !warm)
    standby == $past(sel_n, 2)); // R6

  AST_DESELECT_NODRIVE: assert property (@(posedge clk) disable iff (rst || !warm)
    $past(sel_n, 2) |-> (rdrive == '0)); // R6

  AST_WRITE_NODRIVE: assert property (@(posedge clk) disable iff (rst || !warm)
    (!$past(sel_n, 2) && !$past(wr_n, 2)) |-> (rdrive == '0)); // R5

  AST_QUIET_NODRIVE: assert property (@(posedge clk) disable iff (rst || !warm)
    (!$past(sel_n, 2) && $past(wr_n, 2) && ($past(oe_n, 2) || $past(lane_en_n, 2) == '1))
      |-> (rdrive == '0 && !standby)); // R7

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    AST_LANE_GATE: assert property (@(posedge clk) disable iff (rst || !warm)
      rdrive[g] |-> !$past(lane_en_n[g], 2)); // R3
    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !rdrive[g] |-> (rdata[g*LANE_W +: LANE_W] == '0)); // R3
  end
endmodule

bind sram16_lane_emu sram16_lane_emu_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
  .lane_en_n(lane_en_n), .rdata(rdata), .rdrive(rdrive), .standby(standby)
);

// File: tb/sram16_lane_emu_bench.sv
`timescale 1ns/1ps
module sram16_lane_emu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
  logic [1:0]  lane_en_n = 2'b11;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  rdrive;
  logic        standby;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sram16_lane_emu u_sram16_lane_emu (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
    .lane_en_n(lane_en_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdrive(rdrive), .standby(standby)
  );

  // control field {sel_n, wr_n, oe_n, lane_en_n[1], lane_en_n[0]}
  // entry: {ctrl5, addr17, wdata16, exp_drive2, exp_standby1, exp_rdata16}
  localparam int NV = 17;
  localparam logic [56:0] VEC [NV] = '{
    {5'b00000, 17'h00010, 16'hA5C3, 2'b00, 1'b0, 16'h0000},
    {5'b01000, 17'h00010, 16'h0000, 2'b11, 1'b0, 16'hA5C3},
    {5'b00110, 17'h00010, 16'hFF11, 2'b00, 1'b0, 16'h0000},
    {5'b01000, 17'h00010, 16'h0000, 2'b11, 1'b0, 16'hA511},
    {5'b00101, 17'h00010, 16'h7E00, 2'b00, 1'b0, 16'h0000},
    {5'b01010, 17'h00010, 16'h0000, 2'b01, 1'b0, 16'h0011},
    {5'b01001, 17'h00010, 16'h0000, 2'b10, 1'b0, 16'h7E00},
    {5'b01100, 17'h00010, 16'h0000, 2'b00, 1'b0, 16'h0000},
    {5'b01011, 17'h00010, 16'h0000, 2'b00, 1'b0, 16'h0000},
    {5'b10000, 17'h00010, 16'h0000, 2'b00, 1'b1, 16'h0000},
    {5'b01000, 17'h00010, 16'h0000, 2'b11, 1'b0, 16'h7E11},
    {5'b00011, 17'h00010, 16'h1234, 2'b00, 1'b0, 16'h0000},
    {5'b01000, 17'h00010, 16'h0000, 2'b11, 1'b0, 16'h7E11},
    {5'b00000, 17'h007FF, 16'hBEEF, 2'b00, 1'b0, 16'h0000},
    {5'b01000, 17'h007FF, 16'h0000, 2'b11, 1'b0, 16'hBEEF},
    {5'b01000, 17'h00010, 16'h0000, 2'b11, 1'b0, 16'h7E11},
    {5'b11000, 17'h00010, 16'h0000, 2'b00, 1'b1, 16'h0000}
  };

  function automatic string tag_of(input logic [4:0] c);
    if (c[4])           return "R6 deselect";
    else if (!c[3])     return "R4/R5 write";
    else if (!c[2] && c[1:0] != 2'b11) return "R2/R3 read";
    else                return "R7 quiet";
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic apply(input logic [4:0] c, input logic [16:0] a, input logic [15:0] d);
    {sel_n, wr_n, oe_n, lane_en_n} = c;
    addr  = a;
    wdata = d;
  endtask

  task automatic idle();
    apply(5'b11111, 17'h0, 16'h0);
  endtask

  task automatic chk(input logic [1:0] ed, input logic es, input logic [15:0] edat,
                     input string tag);
    checks++;
    if (rdrive !== ed || standby !== es || rdata !== edat) begin
      failures++;
      $display("FAIL %s: drive=%b/%b standby=%b/%b data=%h/%h (actual/expected)",
               tag, rdrive, ed, standby, es, rdata, edat);
    end
  endtask

  // one operation, then an idle sample, then the result is visible
  task automatic op(input logic [4:0] c, input logic [16:0] a, input logic [15:0] d);
    apply(c, a, d); step(); idle(); step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with read-like pins applied during reset
    apply(5'b01000, 17'h0, 16'h0);
    step(); step(); step();
    chk(2'b00, 1'b1, 16'h0000, "R1 reset state");
    rst = 1'b0;
    idle(); step(); step();
    chk(2'b00, 1'b1, 16'h0000, "R1 idle after reset");

    // vector table: R2 R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      op(VEC[i][56:52], VEC[i][51:35], VEC[i][34:19]);
      chk(VEC[i][18:17], VEC[i][16], VEC[i][15:0], tag_of(VEC[i][56:52]));
    end

    // R8: long write, data and address change inside the window, wr_n ends it
    op(5'b00000, 17'h00020, 16'hAAAA);
    apply(5'b00000, 17'h00020, 16'h1111); step();
    apply(5'b00000, 17'h00020, 16'h2222); step();
    apply(5'b00000, 17'h00021, 16'h3333); step();
    apply(5'b01100, 17'h00021, 16'h0000); step();
    idle(); step();
    op(5'b01000, 17'h00021, 16'h0);
    chk(2'b11, 1'b0, 16'h3333, "R8 last sample committed");
    op(5'b01000, 17'h00020, 16'h0);
    chk(2'b11, 1'b0, 16'hAAAA, "R8 earlier samples not stored");

    // R8: sel_n ends the write while wr_n stays low
    apply(5'b00000, 17'h00030, 16'h5A5A); step();
    apply(5'b10000, 17'h00030, 16'h0000); step();
    idle(); step();
    op(5'b01000, 17'h00030, 16'h0);
    chk(2'b11, 1'b0, 16'h5A5A, "R8 select-terminated write");

    // R9: read right after the write, same address, both lanes
    apply(5'b00000, 17'h00040, 16'hC0DE); step();
    apply(5'b01000, 17'h00040, 16'h0000); step();
    idle(); step();
    chk(2'b11, 1'b0, 16'hC0DE, "R9 bypass both lanes");

    // R9: low lane only written, high lane from array
    apply(5'b00110, 17'h00040, 16'h9977); step();
    apply(5'b01000, 17'h00040, 16'h0000); step();
    idle(); step();
    chk(2'b11, 1'b0, 16'hC077, "R9 bypass low lane only");

    // R9: different address read right after write, no false bypass
    apply(5'b00000, 17'h00041, 16'h1357); step();
    apply(5'b01000, 17'h00040, 16'h0000); step();
    idle(); step();
    chk(2'b11, 1'b0, 16'hC077, "R9 other address from array");
    op(5'b01000, 17'h00041, 16'h0);
    chk(2'b11, 1'b0, 16'h1357, "R9 neighbour stored");

    // R1: mid-run reset keeps array contents
    apply(5'b01000, 17'h00040, 16'h0);
    rst = 1'b1; step(); step();
    chk(2'b00, 1'b1, 16'h0000, "R1 mid-run reset");
    rst = 1'b0; idle(); step(); step();
    op(5'b01000, 17'h00040, 16'h0);
    chk(2'b11, 1'b0, 16'hC077, "R1 contents kept over reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule